// File: doc/BRIEF.md
# Bitplane-Serial Multiplication-Free Correlator

This block correlates a signed input vector `x` with a signed weight vector `w` of the same length. It does not multiply full-precision values. The correlation it returns is the sum over every lane of `sign(x)·|w| + sign(w)·|x|`. Each of the two terms is rewritten as twice an AND-and-popcount sum against one-bit "non-negative" flags, minus a residue.

- The residue `Σ|x|` is found by running the input bitplanes against an implicit all-ones row in the same cycles.
- The residue `Σ|w|` is a precomputed weight statistic that the caller supplies on its own port.

The datapath walks the weight magnitude bitplanes first, one per cycle, with the input flags held fixed. It then walks the input magnitude bitplanes, one per cycle, with the weight flags held fixed. Each plane's popcount is shifted by its plane index and added to a running sum. One final cycle forms the signed result.

Operands are sign-magnitude lanes, one sign bit plus `MAG_W` magnitude bits. A run-time skip count drops the least significant weight planes to trade precision for cycles.

Operands enter through a valid/ready port. `in_ready` is high only while the block is idle. A beat is taken on a clock edge where both `in_valid` and `in_ready` are high. Holding `in_valid` high while `in_ready` is low does nothing, so a source is back-pressured simply by the block being busy. The result leaves on a plain `done` strobe with no back-pressure. It stays on `result` until the next operation completes.

Top module: `mfcorr_top`

## Requirements
- R1: After reset, `done` is 0, `result` is 0 and `in_ready` is 1.
- R2: An operation is accepted on a clock edge where `in_valid` and `in_ready` are both 1. `in_ready` reads 0 from the next cycle until the cycle in which `done` is 1.
- R3: Lane `i` has its sign at `x_sign[i]` / `w_sign[i]` and its magnitude at `x_mag[i*MAG_W +: MAG_W]` / `w_mag[i*MAG_W +: MAG_W]`. A sign bit of 1 means negative (sign −1) and a sign bit of 0 means sign +1. `result` equals Σ_i [sign(x_i)·|w_i| + sign(w_i)·|x_i|] as a two's complement value.
- R4: A lane with sign bit 1 and magnitude 0 still counts as sign −1 against the other operand's magnitude.
- R5: With `skip_planes` = k < MAG_W, weight magnitude bits 0..k-1 count as zero. `w_abs_sum` must be given as Σ of the weight magnitudes with those bits cleared. The result then follows R3 with the truncated weight magnitudes.
- R6: With `skip_planes` ≥ MAG_W, every weight magnitude counts as zero. The result is Σ sign(w_i)·|x_i| − `w_abs_sum`, with `w_abs_sum` = 0 expected.
- R7: `done` rises exactly 2·MAG_W − min(k, MAG_W) + 1 clock edges after the accepting edge.
- R8: `done` is high for exactly one cycle. `result` changes only in a cycle where `done` is 1, and otherwise holds its value whatever the inputs do.
- R9: `in_valid` raised while an operation is in progress is ignored. The running operation's result is unaffected and no extra `done` follows.
- R10: `result` never leaves the range ±2·LANES·(2^MAG_W − 1). Both extremes are reached: all lanes positive at full scale give the upper bound, and all lanes negative at full scale give the lower bound.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand beat offered |
| in_ready | output | 1 | Block idle and able to take a beat |
| x_sign | input | LANES | Input sign bits, 1 = negative |
| x_mag | input | LANES·MAG_W | Input magnitudes, lane i at bits i·MAG_W upward |
| w_sign | input | LANES | Weight sign bits, 1 = negative |
| w_mag | input | LANES·MAG_W | Weight magnitudes, same packing as x_mag |
| w_abs_sum | input | MAG_W+clog2(LANES+1) | Precomputed sum of truncated weight magnitudes |
| skip_planes | input | clog2(MAG_W+1) | Number of low weight planes to skip |
| done | output | 1 | One-cycle completion strobe |
| result | output | MAG_W+clog2(LANES+1)+2 | Signed correlation, held until next completion |

## Verification
The hardest state to reach from the ports is a second beat offered mid-operation, with different operands, while the first operation is still walking its planes. The stimulus raises `in_valid` a few cycles after acceptance and keeps it up across several plane steps. It then checks that the first result is returned with unchanged latency and that no second `done` arrives. Negative-zero lanes and a skip count at or above the magnitude width are also rare in natural data, so the vector table contains them explicitly. Each table vector is checked both for its correlation value and for its exact completion latency.

// File: rtl/mfcorr_pkg.sv
package mfcorr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WPLN  = 2'd1,
    ST_XPLN  = 2'd2,
    ST_FINAL = 2'd3
  } mfcorr_state_e;
endpackage

// File: rtl/mfcorr_popcnt.sv
module mfcorr_popcnt #(
  parameter int N  = 8,
  parameter int CW = 4
) (
  input  logic [N-1:0]  bits,
  output logic [CW-1:0] count
);
  always_comb begin
    count = '0;
    for (int i = 0; i < N; i++) begin
      count = count + CW'(bits[i]);
    end
  end
endmodule

// File: rtl/mfcorr_plane_pick.sv
module mfcorr_plane_pick #(
  parameter int N     = 8,
  parameter int MAG_W = 7,
  parameter int PW    = 3
) (
  input  logic [N*MAG_W-1:0] mag,
  input  logic [PW-1:0]      idx,
  output logic [N-1:0]       plane
);
  for (genvar i = 0; i < N; i++) begin : g_lane
    logic [MAG_W-1:0] lane;
    assign lane     = mag[i*MAG_W +: MAG_W];
    assign plane[i] = (idx < PW'(MAG_W)) ? lane[idx] : 1'b0;
  end
endmodule

// File: rtl/mfcorr_shacc.sv
module mfcorr_shacc #(
  parameter int CW    = 4,
  parameter int PW    = 3,
  parameter int ACC_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic [CW-1:0]    count,
  input  logic [PW-1:0]    shift,
  output logic [ACC_W-1:0] acc
);
  logic [ACC_W-1:0] term;
  assign term = ACC_W'(count) << shift;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) acc <= '0;
    else if (en)       acc <= acc + term;
  end
endmodule

// File: rtl/mfcorr_seq.sv
module mfcorr_seq
  import mfcorr_pkg::*;
#(
  parameter int MAG_W = 7,
  parameter int PW    = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [PW-1:0] skip,
  output logic          in_ready,
  output logic          accept,
  output logic          en_w,
  output logic          en_x,
  output logic          fin,
  output logic [PW-1:0] plane
);
  mfcorr_state_e state;
  logic          last_plane;

  assign in_ready   = (state == ST_IDLE);
  assign accept     = in_ready && in_valid;
  assign en_w       = (state == ST_WPLN);
  assign en_x       = (state == ST_XPLN);
  assign fin        = (state == ST_FINAL);
  assign last_plane = (plane == PW'(MAG_W - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      plane <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (in_valid) begin
          if (skip < PW'(MAG_W)) begin
            state <= ST_WPLN;
            plane <= skip;
          end else begin
            state <= ST_XPLN;
            plane <= '0;
          end
        end
        ST_WPLN: begin
          if (last_plane) begin
            state <= ST_XPLN;
            plane <= '0;
          end else begin
            plane <= plane + 1'b1;
          end
        end
        ST_XPLN: begin
          if (last_plane) state <= ST_FINAL;
          else            plane <= plane + 1'b1;
        end
        ST_FINAL: state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mfcorr_top.sv
module mfcorr_top #(
  parameter int LANES = 8,
  parameter int MAG_W = 7,
  localparam int PW    = $clog2(MAG_W + 1),
  localparam int CW    = $clog2(LANES + 1),
  localparam int ACC_W = MAG_W + CW,
  localparam int RES_W = ACC_W + 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [LANES-1:0]        x_sign,
  input  logic [LANES*MAG_W-1:0]  x_mag,
  input  logic [LANES-1:0]        w_sign,
  input  logic [LANES*MAG_W-1:0]  w_mag,
  input  logic [ACC_W-1:0]        w_abs_sum,
  input  logic [PW-1:0]           skip_planes,
  output logic                    done,
  output logic signed [RES_W-1:0] result
);
  logic             accept, en_w, en_x, fin;
  logic [PW-1:0]    plane;
  logic [LANES-1:0] xstep_q, wstep_q;
  logic [LANES*MAG_W-1:0] xmag_q, wmag_q;
  logic [ACC_W-1:0] wsum_q;
  logic [LANES-1:0] wplane, xplane;
  logic [CW-1:0]    cnt_wx, cnt_xw, cnt_xs;
  logic [ACC_W-1:0] acc_wx, acc_xw, acc_xs;
  logic [RES_W-1:0] fin_val;

  mfcorr_seq #(.MAG_W(MAG_W), .PW(PW)) u_seq (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .skip(skip_planes),
    .in_ready(in_ready), .accept(accept), .en_w(en_w), .en_x(en_x),
    .fin(fin), .plane(plane)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      xstep_q <= '0;
      wstep_q <= '0;
      xmag_q  <= '0;
      wmag_q  <= '0;
      wsum_q  <= '0;
    end else if (accept) begin
      xstep_q <= ~x_sign;
      wstep_q <= ~w_sign;
      xmag_q  <= x_mag;
      wmag_q  <= w_mag;
      wsum_q  <= w_abs_sum;
    end
  end

  mfcorr_plane_pick #(.N(LANES), .MAG_W(MAG_W), .PW(PW)) u_wpick (
    .mag(wmag_q), .idx(plane), .plane(wplane)
  );
  mfcorr_plane_pick #(.N(LANES), .MAG_W(MAG_W), .PW(PW)) u_xpick (
    .mag(xmag_q), .idx(plane), .plane(xplane)
  );

  mfcorr_popcnt #(.N(LANES), .CW(CW)) u_pc_wx (.bits(xstep_q & wplane), .count(cnt_wx));
  mfcorr_popcnt #(.N(LANES), .CW(CW)) u_pc_xw (.bits(wstep_q & xplane), .count(cnt_xw));
  mfcorr_popcnt #(.N(LANES), .CW(CW)) u_pc_xs (.bits(xplane),           .count(cnt_xs));

  mfcorr_shacc #(.CW(CW), .PW(PW), .ACC_W(ACC_W)) u_acc_wx (
    .clk(clk), .rst_n(rst_n), .clr(accept), .en(en_w),
    .count(cnt_wx), .shift(plane), .acc(acc_wx)
  );
  mfcorr_shacc #(.CW(CW), .PW(PW), .ACC_W(ACC_W)) u_acc_xw (
    .clk(clk), .rst_n(rst_n), .clr(accept), .en(en_x),
    .count(cnt_xw), .shift(plane), .acc(acc_xw)
  );
  mfcorr_shacc #(.CW(CW), .PW(PW), .ACC_W(ACC_W)) u_acc_xs (
    .clk(clk), .rst_n(rst_n), .clr(accept), .en(en_x),
    .count(cnt_xs), .shift(plane), .acc(acc_xs)
  );

  assign fin_val = (RES_W'(acc_wx) << 1) + (RES_W'(acc_xw) << 1)
                 - RES_W'(wsum_q) - RES_W'(acc_xs);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done   <= 1'b0;
      result <= '0;
    end else begin
      done <= fin;
      if (fin) result <= $signed(fin_val);
    end
  end
endmodule

// File: rtl/mfcorr_chk.sv
module mfcorr_chk #(
  parameter int LANES = 8,
  parameter int MAG_W = 7,
  parameter int RES_W = 13
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_valid,
  input logic                    in_ready,
  input logic                    done,
  input logic signed [RES_W-1:0] result
);
  localparam int LIMIT   = 2 * LANES * ((1 << MAG_W) - 1);
  localparam int MAX_BSY = 2 * MAG_W + 1;

  int busy_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n)        busy_cnt <= 0;
    else if (in_ready) busy_cnt <= 0;
    else               busy_cnt <= busy_cnt + 1;
  end

  p_reset_idle_r1: assert property (@(posedge clk) $rose(rst_n) |-> in_ready && !done);

  p_busy_after_take_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  p_latency_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy_cnt <= MAX_BSY);

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_hold_result_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(result) |-> done);

  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> in_ready);

  p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (result <= LIMIT) && (result >= -LIMIT));
endmodule

bind mfcorr_top mfcorr_chk #(.LANES(LANES), .MAG_W(MAG_W), .RES_W(RES_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .done(done), .result(result)
);

// File: tb/tb_mfcorr_top.sv
module tb_mfcorr_top;
  localparam int LANES = 8;
  localparam int MAG_W = 7;
  localparam int PW    = $clog2(MAG_W + 1);
  localparam int ACC_W = MAG_W + $clog2(LANES + 1);
  localparam int RES_W = ACC_W + 2;
  localparam int NV    = 9;

  // each lane is one byte {sign, mag[6:0]}, lane i at bits i*8
  localparam logic [63:0] T_X [NV] = '{
    64'h0102030405060708, 64'h81057F80220C43A0, 64'h81057F80220C43A0,
    64'h9A2345E7116C800F, 64'h7F7F7F7F7F7F7F7F, 64'hFFFFFFFFFFFFFFFF,
    64'h83107F0022C5E601, 64'h8080000080008000, 64'h00FF7F80017E81FE
  };
  localparam logic [63:0] T_W [NV] = '{
    64'h0807060504030201, 64'h7F831000AA5580FF, 64'h7F831000AA5580FF,
    64'hC33C5AA5F00F9966, 64'h7F7F7F7F7F7F7F7F, 64'hFFFFFFFFFFFFFFFF,
    64'h7FFF7FFF7FFF7FFF, 64'h0585058580000080, 64'hFF00807F7E0181FE
  };
  localparam logic [2:0] T_SK [NV] = '{3'd0, 3'd0, 3'd2, 3'd4, 3'd0, 3'd0, 3'd7, 3'd1, 3'd6};
  localparam string T_REQ [NV] = '{"R3", "R3", "R5", "R5", "R10", "R10", "R6", "R4", "R5"};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [LANES-1:0] x_sign = '0, w_sign = '0;
  logic [LANES*MAG_W-1:0] x_mag = '0, w_mag = '0;
  logic [ACC_W-1:0] w_abs_sum = '0;
  logic [PW-1:0] skip_planes = '0;
  logic done;
  logic signed [RES_W-1:0] result;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  mfcorr_top #(.LANES(LANES), .MAG_W(MAG_W)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .x_sign(x_sign), .x_mag(x_mag), .w_sign(w_sign), .w_mag(w_mag),
    .w_abs_sum(w_abs_sum), .skip_planes(skip_planes),
    .done(done), .result(result)
  );

  function automatic int sat_skip(input int k);
    return (k > MAG_W) ? MAG_W : k;
  endfunction

  function automatic int model_corr(input logic [63:0] x, input logic [63:0] w, input int k);
    int s = 0;
    for (int i = 0; i < LANES; i++) begin
      int sx = x[i*8+7] ? -1 : 1;
      int sw = w[i*8+7] ? -1 : 1;
      int mx = int'(x[i*8 +: 7]);
      int mw = (int'(w[i*8 +: 7]) >> sat_skip(k)) << sat_skip(k);
      s += sx * mw + sw * mx;
    end
    return s;
  endfunction

  function automatic int model_wsum(input logic [63:0] w, input int k);
    int s = 0;
    for (int i = 0; i < LANES; i++) s += (int'(w[i*8 +: 7]) >> sat_skip(k)) << sat_skip(k);
    return s;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_ops(input logic [63:0] x, input logic [63:0] w, input int k);
    for (int i = 0; i < LANES; i++) begin
      x_sign[i] = x[i*8+7];
      w_sign[i] = w[i*8+7];
      x_mag[i*MAG_W +: MAG_W] = x[i*8 +: 7];
      w_mag[i*MAG_W +: MAG_W] = w[i*8 +: 7];
    end
    w_abs_sum = ACC_W'(model_wsum(w, k));
    skip_planes = PW'(k);
  endtask

  // count edges after the accepting edge until done is seen
  task automatic wait_done(output int lat);
    lat = 0;
    forever begin
      @(posedge clk);
      lat++;
      @(negedge clk);
      if (done || lat > 64) break;
    end
  endtask

  task automatic run_op(input logic [63:0] x, input logic [63:0] w, input int k, input string req);
    int lat;
    int exp_lat = 2 * MAG_W - sat_skip(k) + 1;
    @(negedge clk);
    set_ops(x, w, k);
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check(in_ready == 1'b0, "R2", int'(in_ready), 0);
    wait_done(lat);
    check(int'(result) == model_corr(x, w, k), req, int'(result), model_corr(x, w, k));
    check(lat == exp_lat, "R7", lat, exp_lat);
    @(negedge clk);
    check(done == 1'b0, "R8", int'(done), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int lat;
    logic signed [RES_W-1:0] held;
    int exp_a;
    int extra;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(done == 1'b0, "R1", int'(done), 0);
    check(result == '0, "R1", int'(result), 0);
    check(in_ready == 1'b1, "R1", int'(in_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready == 1'b1, "R1", int'(in_ready), 1);

    for (int v = 0; v < NV; v++) run_op(T_X[v], T_W[v], int'(T_SK[v]), T_REQ[v]);

    // R9: a beat offered while busy is ignored
    exp_a = model_corr(T_X[1], T_W[1], 0);
    @(negedge clk);
    set_ops(T_X[1], T_W[1], 0);
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    set_ops(T_X[4], T_W[4], 0);
    in_valid = 1'b1;
    repeat (4) @(negedge clk);
    in_valid = 1'b0;
    lat = 7;
    begin
      int more;
      wait_done(more);
      lat += more;
    end
    check(int'(result) == exp_a, "R9", int'(result), exp_a);
    check(lat == 2 * MAG_W + 1, "R9", lat, 2 * MAG_W + 1);
    extra = 0;
    for (int c = 0; c < 2 * MAG_W + 4; c++) begin
      @(negedge clk);
      if (done) extra++;
    end
    check(extra == 0, "R9", extra, 0);

    // R8: result holds while inputs change and no beat is offered
    held = result;
    set_ops(T_X[5], T_W[5], 3);
    for (int c = 0; c < 10; c++) begin
      @(negedge clk);
      x_mag = x_mag ^ {LANES*MAG_W{1'b1}};
      w_sign = ~w_sign;
    end
    check(result == held, "R8", int'(result), int'(held));
    check(done == 1'b0, "R8", int'(done), 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule